// File: doc/BRIEF.md
# Cross-Trigger Event Routing Matrix

This block routes debug and trace trigger events between subsystems. A set of trigger-input lines is folded onto a few broadcast channels through per-input channel masks. Each trigger output watches the channels through its own mask and latches when any watched channel is active. Software can also raise channels directly, either as a held level or as a single-cycle pulse.

A latched output stays high until software acknowledges it, so it can drive an interrupt line directly. Everything is programmed through a simple register port with a 32-bit address, write data, a write strobe, a read strobe and registered read data. A key register guards every other register. The unit leaves reset locked, and no write has any effect until the key has been written.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset, all trigger outputs are 0, the control register reads 0, and lock status (offset 0xFB4) reads 0x3. Bit 0 of lock status is the lock-support flag and is always 1. Bit 1 is 1 while the unit is locked.
- R2: Writing 0xC5ACCE55 to offset 0xFB0 unlocks the unit, and lock status then reads 0x1. Writing any other value to 0xFB0 locks it again. While the unit is locked, writes to every other offset have no effect.
- R3: Input i has a channel mask at 0x020+4*i, and output j has one at 0x0A0+4*j. Bit c of a mask selects channel c. While control bit 0 (offset 0x000) is 1, an input held high for one cycle sets every output whose mask shares a channel with that input's mask. The output changes at the clock edge that samples the input.
- R4: A set output stays high after the input that caused it goes low.
- R5: Writing 1 to bit j of offset 0x010 clears output j at that edge. If output j's routed channel is active in the same cycle, the output stays set.
- R6: While control bit 0 is 0, no output is newly set, and outputs that are already set keep their value.
- R7: Writing to offset 0x014 sets the channel bits given in the write data. Those channels stay active until the same bits are written to offset 0x018. Offset 0x014 reads back the held bits.
- R8: Writing to offset 0x01C makes the given channels active for exactly one cycle. This sets the routed outputs, and the channel-input status afterwards reads 0.
- R9: Status offsets read as follows: 0x130 reads the raw trigger inputs, 0x134 the trigger outputs, 0x138 the active channels before the global enable, and 0x13C the active channels after it. The mask registers read back their stored values.
- R10: Offsets 0xFE0 to 0xFFC read 0xB0+k, where k is (offset-0xFE0)/4. Any address that is not mapped reads 0, and so does any address with a nonzero bit above bit 11.
- R11: Read data appears on rdata_o at the edge where re_i is sampled high, and it holds while re_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_in_i | input | NUM_IN | Trigger event inputs |
| trig_out_o | output | NUM_OUT | Latched trigger outputs |
| addr_i | input | 32 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions assume trigger inputs are synchronous to clk_i. They also assume that every write strobe lasts a single cycle, and that write and read strobes are never raised in the same cycle. The stimulus drives every input at the falling edge, pulses each strobe for exactly one cycle, and issues writes and reads one at a time. The output-hold property assumes the only way an output drops is an acknowledge write at offset 0x010. The bench therefore acknowledges only through that register.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam logic [11:0] OFF_CTRL  = 12'h000;
  localparam logic [11:0] OFF_ACK   = 12'h010;
  localparam logic [11:0] OFF_ASET  = 12'h014;
  localparam logic [11:0] OFF_ACLR  = 12'h018;
  localparam logic [11:0] OFF_APUL  = 12'h01C;
  localparam logic [11:0] OFF_INEN  = 12'h020;
  localparam logic [11:0] OFF_OUTEN = 12'h0A0;
  localparam logic [11:0] OFF_TIN   = 12'h130;
  localparam logic [11:0] OFF_TOUT  = 12'h134;
  localparam logic [11:0] OFF_CIN   = 12'h138;
  localparam logic [11:0] OFF_COUT  = 12'h13C;
  localparam logic [11:0] OFF_LOCK  = 12'hFB0;
  localparam logic [11:0] OFF_LSTAT = 12'hFB4;
  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
  localparam logic [7:0]  ID_BASE    = 8'hB0;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  parameter int NUM_CH  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [31:0]                     addr_i,
  input  logic [31:0]                     wdata_i,
  input  logic                            we_i,
  input  logic                            re_i,
  input  logic [NUM_IN-1:0]               trig_in_i,
  input  logic [NUM_OUT-1:0]              trig_out_i,
  input  logic [NUM_CH-1:0]               ch_in_i,
  input  logic [NUM_CH-1:0]               ch_out_i,
  output logic [31:0]                     rdata_o,
  output logic                            ctrl_en_o,
  output logic                            unlocked_o,
  output logic [NUM_IN-1:0][NUM_CH-1:0]   in_en_o,
  output logic [NUM_OUT-1:0][NUM_CH-1:0]  out_en_o,
  output logic [NUM_CH-1:0]               app_set_o,
  output logic [NUM_CH-1:0]               app_pulse_o,
  output logic [NUM_OUT-1:0]              ack_o
);
  logic [11:0] off;
  logic        in_page;
  logic        wr_ok;
  logic [31:0] rd_val;

  assign off     = addr_i[11:0];
  assign in_page = (addr_i[31:12] == '0);
  // lock register is always writable; everything else needs the key
  assign wr_ok   = we_i && in_page && unlocked_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_o  <= 1'b0;
      ctrl_en_o   <= 1'b0;
      app_set_o   <= '0;
      app_pulse_o <= '0;
    end else begin
      app_pulse_o <= '0;
      if (we_i && in_page && off == OFF_LOCK)
        unlocked_o <= (wdata_i == UNLOCK_KEY);
      if (wr_ok) begin
        case (off)
          OFF_CTRL: ctrl_en_o   <= wdata_i[0];
          OFF_ASET: app_set_o   <= app_set_o | wdata_i[NUM_CH-1:0];
          OFF_ACLR: app_set_o   <= app_set_o & ~wdata_i[NUM_CH-1:0];
          OFF_APUL: app_pulse_o <= wdata_i[NUM_CH-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        in_en_o[gi] <= '0;
      else if (wr_ok && off == OFF_INEN + 12'(4 * gi))
        in_en_o[gi] <= wdata_i[NUM_CH-1:0];
    end
  end

  for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        out_en_o[go] <= '0;
      else if (wr_ok && off == OFF_OUTEN + 12'(4 * go))
        out_en_o[go] <= wdata_i[NUM_CH-1:0];
    end
  end

  assign ack_o = (wr_ok && off == OFF_ACK) ? wdata_i[NUM_OUT-1:0] : '0;

  always_comb begin
    rd_val = '0;
    if (in_page) begin
      case (off)
        OFF_CTRL:  rd_val = {31'b0, ctrl_en_o};
        OFF_ASET:  rd_val = 32'(app_set_o);
        OFF_TIN:   rd_val = 32'(trig_in_i);
        OFF_TOUT:  rd_val = 32'(trig_out_i);
        OFF_CIN:   rd_val = 32'(ch_in_i);
        OFF_COUT:  rd_val = 32'(ch_out_i);
        OFF_LSTAT: rd_val = {30'b0, ~unlocked_o, 1'b1};
        default: ;
      endcase
      for (int i = 0; i < NUM_IN; i++)
        if (off == OFF_INEN + 12'(4 * i)) rd_val = 32'(in_en_o[i]);
      for (int j = 0; j < NUM_OUT; j++)
        if (off == OFF_OUTEN + 12'(4 * j)) rd_val = 32'(out_en_o[j]);
      if (off[11:5] == 7'h7F && off[1:0] == 2'b00)
        rd_val = {24'b0, ID_BASE + {5'b0, off[4:2]}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  parameter int NUM_CH  = 4
) (
  input  logic [NUM_IN-1:0]               trig_in_i,
  input  logic [NUM_IN-1:0][NUM_CH-1:0]   in_en_i,
  input  logic [NUM_OUT-1:0][NUM_CH-1:0]  out_en_i,
  input  logic [NUM_CH-1:0]               app_set_i,
  input  logic [NUM_CH-1:0]               app_pulse_i,
  input  logic                            en_i,
  output logic [NUM_CH-1:0]               ch_in_o,
  output logic [NUM_CH-1:0]               ch_out_o,
  output logic [NUM_OUT-1:0]              hit_o
);
  always_comb begin
    ch_in_o = app_set_i | app_pulse_i;
    for (int i = 0; i < NUM_IN; i++)
      if (trig_in_i[i]) ch_in_o = ch_in_o | in_en_i[i];
  end

  assign ch_out_o = en_i ? ch_in_o : '0;

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_hit
    assign hit_o[j] = |(ch_out_o & out_en_i[j]);
  end
endmodule

// File: rtl/xtrig_latch.sv
module xtrig_latch #(
  parameter int NUM_OUT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OUT-1:0] hit_i,
  input  logic [NUM_OUT-1:0] ack_i,
  output logic [NUM_OUT-1:0] q_o
);
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_bit
    // a new event in the ack cycle wins so it is not lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[j] <= 1'b0;
      else if (hit_i[j]) q_o[j] <= 1'b1;
      else if (ack_i[j]) q_o[j] <= 1'b0;
    end
  end
endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix #(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  parameter int NUM_CH  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IN-1:0]  trig_in_i,
  output logic [NUM_OUT-1:0] trig_out_o,
  input  logic [31:0]        addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [31:0]        rdata_o
);
  logic                           ctrl_en;
  logic                           unlocked;
  logic [NUM_IN-1:0][NUM_CH-1:0]  in_en;
  logic [NUM_OUT-1:0][NUM_CH-1:0] out_en;
  logic [NUM_CH-1:0]              app_set, app_pulse, ch_in, ch_out;
  logic [NUM_OUT-1:0]             ack, hit;

  xtrig_regs #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .trig_in_i(trig_in_i), .trig_out_i(trig_out_o),
    .ch_in_i(ch_in), .ch_out_i(ch_out), .rdata_o(rdata_o),
    .ctrl_en_o(ctrl_en), .unlocked_o(unlocked), .in_en_o(in_en),
    .out_en_o(out_en), .app_set_o(app_set), .app_pulse_o(app_pulse), .ack_o(ack)
  );

  xtrig_route #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_route (
    .trig_in_i(trig_in_i), .in_en_i(in_en), .out_en_i(out_en),
    .app_set_i(app_set), .app_pulse_i(app_pulse), .en_i(ctrl_en),
    .ch_in_o(ch_in), .ch_out_o(ch_out), .hit_o(hit)
  );

  xtrig_latch #(.NUM_OUT(NUM_OUT)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .ack_i(ack), .q_o(trig_out_o)
  );
endmodule

// File: rtl/xtrig_matrix_chk.sv
module xtrig_matrix_chk #(
  parameter int NUM_OUT = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic               re_i,
  input logic [31:0]        addr_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic [NUM_OUT-1:0] trig_out_o,
  input logic               ctrl_en,
  input logic               unlocked,
  input logic [NUM_OUT-1:0] hit
);
  a_r2_locked_ignores_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && we_i && addr_i != 32'h0000_0FB0) |=> $stable(ctrl_en));

  a_r6_disabled_no_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en |=> ((trig_out_o & ~$past(trig_out_o)) == '0));

  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    a_r3_hit_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[j] |=> trig_out_o[j]);
    a_r4_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_out_o[j] && !(we_i && addr_i == 32'h0000_0010 && wdata_i[j]))
      |=> trig_out_o[j]);
  end
endmodule

bind xtrig_matrix xtrig_matrix_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .trig_out_o(trig_out_o),
  .ctrl_en(ctrl_en), .unlocked(unlocked), .hit(hit)
);

// File: tb/xtrig_matrix_tb.sv
module xtrig_matrix_tb;
  localparam int NI = 8;
  localparam int NO = 8;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] trig_in = '0;
  logic [NO-1:0] trig_out;
  logic [31:0]   addr = '0, wdata = '0, rdata;
  logic          we = 1'b0, re = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire = 1'b0;
  logic [31:0] last_rd = '0;

  always #10 clk = ~clk;

  xtrig_matrix u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_in_i(trig_in), .trig_out_o(trig_out),
    .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) rd_fire <= re;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q[0]);
        last_rd = exp_q.pop_front();
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 outputs", 32'(trig_out), 32'h0);
    rd(32'hFB4, 32'h3, "R1 lock status");
    rd(32'h000, 32'h0, "R1 control");

    wr(32'h000, 32'h1);
    rd(32'h000, 32'h0, "R2 locked write ignored");
    wr(32'hFB0, KEY);
    rd(32'hFB4, 32'h1, "R2 unlocked status");

    wr(32'h028, 32'h2);          // input 2 -> channel 1
    wr(32'h0B4, 32'h2);          // channel 1 -> output 5
    wr(32'h000, 32'h1);
    rd(32'h028, 32'h2, "R9 input mask readback");
    rd(32'h0B4, 32'h2, "R9 output mask readback");
    @(negedge clk) trig_in = 8'h04;
    @(negedge clk) trig_in = 8'h00;
    check("R3 route in2->out5", 32'(trig_out), 32'h20);
    tick(4);
    check("R4 held after input low", 32'(trig_out), 32'h20);
    rd(32'h134, 32'h20, "R9 output status");

    trig_in = 8'h04;
    rd(32'h130, 32'h04, "R9 raw input status");
    rd(32'h138, 32'h2, "R9 channel in status");
    rd(32'h13C, 32'h2, "R9 channel out status");
    wr(32'h010, 32'h20);
    check("R5 ack while active keeps set", 32'(trig_out), 32'h20);
    trig_in = 8'h00;
    wr(32'h010, 32'h20);
    check("R5 ack clears", 32'(trig_out), 32'h0);

    @(negedge clk) trig_in = 8'h04;
    @(negedge clk) trig_in = 8'h00;
    wr(32'h000, 32'h0);
    trig_in = 8'h04;
    rd(32'h13C, 32'h0, "R9 channel out gated by enable");
    rd(32'h138, 32'h2, "R9 channel in before enable");
    trig_in = 8'h00;
    check("R6 latched kept while disabled", 32'(trig_out), 32'h20);
    wr(32'h010, 32'h20);
    @(negedge clk) trig_in = 8'h04;
    @(negedge clk) trig_in = 8'h00;
    check("R6 no new latch while disabled", 32'(trig_out), 32'h0);

    wr(32'h000, 32'h1);
    wr(32'h084 - 32'h80 + 32'h80, 32'h0);  // input 25 slot is unmapped for 8 inputs
    wr(32'h0A4, 32'h8);          // channel 3 -> output 1
    wr(32'h014, 32'h8);
    tick(1);
    check("R7 app set latches out1", 32'(trig_out), 32'h02);
    rd(32'h014, 32'h8, "R7 app set readback");
    wr(32'h018, 32'h8);
    rd(32'h014, 32'h0, "R7 app clear readback");
    wr(32'h010, 32'h02);
    tick(1);
    check("R7 cleared channel no relatch", 32'(trig_out), 32'h0);

    wr(32'h01C, 32'h8);
    tick(1);
    check("R8 pulse latches out1", 32'(trig_out), 32'h02);
    rd(32'h138, 32'h0, "R8 pulse lasts one cycle");
    wr(32'h010, 32'h02);
    check("R8 ack after pulse", 32'(trig_out), 32'h0);

    wr(32'h020, 32'h1);          // input 0 -> channel 0
    wr(32'h0AC, 32'h1);          // channel 0 -> output 3
    wr(32'h0B8, 32'h1);          // channel 0 -> output 6
    @(negedge clk) trig_in = 8'h01;
    @(negedge clk) trig_in = 8'h00;
    check("R3 fan-out in0->out3,out6", 32'(trig_out), 32'h48);
    wr(32'h010, 32'h48);

    rd(32'h200, 32'h0, "R10 unmapped reads zero");
    rd(32'hFE0, 32'hB0, "R10 id first");
    rd(32'hFFC, 32'hB7, "R10 id last");
    rd(32'h1000_0000, 32'h0, "R10 high address reads zero");

    wr(32'hFB0, 32'h0);
    rd(32'hFB4, 32'h3, "R2 relocked status");
    wr(32'h000, 32'h0);
    rd(32'h000, 32'h1, "R2 relocked write ignored");
    tick(3);
    check("R11 read data holds", rdata, last_rd);

    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule